// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope analog-to-digital converter. A request on `start_i` makes it steer the external integrator onto the unknown voltage and let a binary counter run for exactly 2^CNT_W clocks, so the first integration lasts a fixed time set by counter rollover. At rollover it steers the integrator onto the negative reference. It then counts clocks until the external comparator reports that the integrator output has crossed zero. The count reached at that point is proportional to the ratio of input voltage to reference, and it is captured as the conversion result.

The fixed first phase is normally matched to the period of the interfering mains signal. For example, 16.667 ms removes 60 Hz pickup. The clock rate is chosen so that 2^CNT_W clocks span that time. If no crossing arrives within 2^CNT_W reference clocks, the input is out of range: the result saturates and a flag is raised. The integrator, the analog switches and the comparator sit outside this block. The sequencer's states are IDLE, INTEG, DEINT and DONE. Its transitions are:

- IDLE to INTEG on start.
- INTEG to DEINT on counter rollover.
- DEINT to DONE on a zero crossing or on reaching the count limit.
- DONE to IDLE unconditionally.

Top module: `dslope_seq`

## Requirements
- R1: After reset the switch select is `3'b100` (open), `eoc_o` and `busy_o` are 0, `result_o` is 0 and `over_range_o` is 0.
- R2: `sw_sel_o` always has exactly one bit set. Bit 0 connects the unknown input, bit 1 connects the negative reference and bit 2 leaves the integrator open. Bit 2 is set in IDLE and DONE.
- R3: A `start_i` sampled high in IDLE makes `sw_sel_o` select the input from the next cycle, for exactly 2^CNT_W cycles. The reference is selected in the cycle that follows.
- R4: During the reference phase, the cycles are numbered from 0. If `zero_cross_i` is first sampled high in cycle j, the result is j, and the reference phase ends after that cycle. `zero_cross_i` has no effect outside the reference phase.
- R5: If `zero_cross_i` stays low for all 2^CNT_W reference cycles, `result_o` becomes all ones and `over_range_o` becomes 1. A crossing in the last reference cycle gives all ones with `over_range_o` 0.
- R6: `eoc_o` is high for exactly one cycle. That cycle immediately follows the end of the reference phase, and in it the switches are open and the new result is already visible. The next cycle is IDLE.
- R7: `start_i` has no effect outside IDLE. The conversion in progress keeps its timing and its result.
- R8: `result_o` and `over_range_o` change only in the cycle where `eoc_o` is high, and hold their values otherwise.
- R9: `busy_o` is high exactly while the input or the reference is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Conversion request, sampled in IDLE |
| zero_cross_i | input | 1 | Comparator: integrator output has crossed zero |
| sw_sel_o | output | 3 | One-hot switch select: bit0 input, bit1 reference, bit2 open |
| busy_o | output | 1 | Conversion phase in progress |
| eoc_o | output | 1 | One-cycle end-of-conversion pulse |
| result_o | output | CNT_W | Reference-phase count (conversion word) |
| over_range_o | output | 1 | No crossing within the reference window |

## Verification
The bound checker watches on every cycle that the switch select stays one-hot, and that `busy_o` agrees with it. It also checks that the input phase always lasts exactly 2^CNT_W cycles and hands over to the reference and never back. Further per-cycle checks are that the end pulse is single and that a saturated result always reads all ones. Finally, the result can move only under the end pulse. Whether the captured count is the right one for a given input-to-reference ratio can only be shown by the bench. There, an integer model of the integrator produces the comparator edge. The bench scenarios also show three other things: that a crossing seen while integrating the input changes nothing, that a second start mid-conversion is ignored, and where the boundary falls between a full-scale result and an over-range one.

// File: rtl/dsl_pkg.sv
package dsl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_INTEG = 2'd1,
        ST_DEINT = 2'd2,
        ST_DONE  = 2'd3
    } dsl_state_e;

    localparam int SEL_W    = 3;
    localparam int SEL_IN   = 0;
    localparam int SEL_REF  = 1;
    localparam int SEL_OPEN = 2;

endpackage

// File: rtl/dsl_counter.sv
module dsl_counter #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             last_o
);
    localparam logic [WIDTH-1:0] CNT_MAX = {WIDTH{1'b1}};

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q <= '0;
        end else if (inc_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == CNT_MAX);
endmodule

// File: rtl/dsl_fsm.sv
module dsl_fsm
    import dsl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             zero_cross_i,
    input  logic             cnt_last_i,
    output logic             cnt_clr_o,
    output logic             cnt_inc_o,
    output logic             latch_o,
    output logic             sat_o,
    output logic [SEL_W-1:0] sw_sel_o,
    output logic             busy_o,
    output logic             eoc_o
);
    dsl_state_e state_q, state_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and counter control
    always_comb begin
        state_d   = state_q;
        cnt_clr_o = 1'b0;
        cnt_inc_o = 1'b0;
        latch_o   = 1'b0;
        sat_o     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cnt_clr_o = 1'b1;
                if (start_i) state_d = ST_INTEG;
            end
            ST_INTEG: begin
                cnt_inc_o = 1'b1;
                if (cnt_last_i) state_d = ST_DEINT;
            end
            ST_DEINT: begin
                if (zero_cross_i) begin
                    latch_o = 1'b1;
                    state_d = ST_DONE;
                end else if (cnt_last_i) begin
                    sat_o   = 1'b1;
                    state_d = ST_DONE;
                end else begin
                    cnt_inc_o = 1'b1;
                end
            end
            ST_DONE: begin
                cnt_clr_o = 1'b1;
                state_d   = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Moore outputs
    always_comb begin
        sw_sel_o = '0;
        busy_o   = 1'b0;
        eoc_o    = 1'b0;
        unique case (state_q)
            ST_IDLE:  sw_sel_o[SEL_OPEN] = 1'b1;
            ST_INTEG: begin
                sw_sel_o[SEL_IN] = 1'b1;
                busy_o           = 1'b1;
            end
            ST_DEINT: begin
                sw_sel_o[SEL_REF] = 1'b1;
                busy_o            = 1'b1;
            end
            ST_DONE: begin
                sw_sel_o[SEL_OPEN] = 1'b1;
                eoc_o              = 1'b1;
            end
            default: sw_sel_o[SEL_OPEN] = 1'b1;
        endcase
    end
endmodule

// File: rtl/dsl_result.sv
module dsl_result #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic             sat_i,
    input  logic [WIDTH-1:0] cnt_i,
    output logic [WIDTH-1:0] result_o,
    output logic             over_o
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_o <= '0;
            over_o   <= 1'b0;
        end else if (latch_i) begin
            result_o <= cnt_i;
            over_o   <= 1'b0;
        end else if (sat_i) begin
            result_o <= {WIDTH{1'b1}};
            over_o   <= 1'b1;
        end
    end
endmodule

// File: rtl/dslope_seq.sv
module dslope_seq
    import dsl_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             zero_cross_i,
    output logic [SEL_W-1:0] sw_sel_o,
    output logic             busy_o,
    output logic             eoc_o,
    output logic [CNT_W-1:0] result_o,
    output logic             over_range_o
);
    logic             cnt_clr, cnt_inc, cnt_last, latch, sat;
    logic [CNT_W-1:0] cnt;

    dsl_counter #(.WIDTH(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cnt_clr),
        .inc_i  (cnt_inc),
        .cnt_o  (cnt),
        .last_o (cnt_last)
    );

    dsl_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .zero_cross_i (zero_cross_i),
        .cnt_last_i   (cnt_last),
        .cnt_clr_o    (cnt_clr),
        .cnt_inc_o    (cnt_inc),
        .latch_o      (latch),
        .sat_o        (sat),
        .sw_sel_o     (sw_sel_o),
        .busy_o       (busy_o),
        .eoc_o        (eoc_o)
    );

    dsl_result #(.WIDTH(CNT_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_i  (latch),
        .sat_i    (sat),
        .cnt_i    (cnt),
        .result_o (result_o),
        .over_o   (over_range_o)
    );
endmodule

// File: rtl/dslope_seq_chk.sv
module dslope_seq_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       sw_sel_o,
    input logic             busy_o,
    input logic             eoc_o,
    input logic [CNT_W-1:0] result_o,
    input logic             over_range_o
);
    localparam int LEN_W = CNT_W + 2;
    localparam logic [LEN_W-1:0] T1_LEN = LEN_W'(1) << CNT_W;

    logic [LEN_W-1:0] in_len;
    always_ff @(posedge clk) begin
        if (!rst_n)          in_len <= '0;
        else if (sw_sel_o[0]) in_len <= in_len + 1'b1;
        else                 in_len <= '0;
    end

    assert_sel_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sw_sel_o) == 1);

    assert_busy_phase_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (sw_sel_o[0] || sw_sel_o[1]));

    assert_t1_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sw_sel_o[0]) |-> (in_len == T1_LEN));

    assert_in_to_ref_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sw_sel_o[0] |=> (sw_sel_o[0] || sw_sel_o[1]));

    assert_ref_no_input_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sw_sel_o[1] |=> !sw_sel_o[0]);

    assert_eoc_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |=> !eoc_o);

    assert_eoc_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_o |-> sw_sel_o[2]);

    assert_sat_ones_R5: assert property (@(posedge clk) disable iff (!rst_n)
        over_range_o |-> (result_o == {CNT_W{1'b1}}));

    assert_result_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_o |-> ($stable(result_o) && $stable(over_range_o)));
endmodule

bind dslope_seq dslope_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sw_sel_o     (sw_sel_o),
    .busy_o       (busy_o),
    .eoc_o        (eoc_o),
    .result_o     (result_o),
    .over_range_o (over_range_o)
);

// File: tb/dslope_seq_tb.sv
module dslope_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 8;
    localparam int N = 1 << W;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic         zero_cross_i = 1'b0;
    logic [2:0]   sw_sel_o;
    logic         busy_o, eoc_o, over_range_o;
    logic [W-1:0] result_o;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // analog environment model
    int  vin = 0, vref = 256;
    longint acc = 0;
    bit  force_zc = 0;

    // cycle reference model
    int m_ph = 0, m_cnt = 0, m_res = 0, m_ovr = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dslope_seq #(.CNT_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .zero_cross_i(zero_cross_i),
        .sw_sel_o(sw_sel_o), .busy_o(busy_o), .eoc_o(eoc_o),
        .result_o(result_o), .over_range_o(over_range_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_res = 0; m_ovr = 0;
        end else begin
            case (m_ph)
                0: if (start_i) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == N-1) begin m_ph = 2; m_cnt = 0; end else m_cnt++;
                2: if (zero_cross_i) begin m_res = m_cnt; m_ovr = 0; m_ph = 3; end
                   else if (m_cnt == N-1) begin m_res = N-1; m_ovr = 1; m_ph = 3; end
                   else m_cnt++;
                default: m_ph = 0;
            endcase
        end
    end

    // per-cycle compare, then integrator and comparator update
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            int exp_sel;
            exp_sel = (m_ph == 1) ? 1 : (m_ph == 2) ? 2 : 4;
            check(sw_sel_o == 3'(exp_sel), "R2 R3 switch select", int'(sw_sel_o), exp_sel);
            check(busy_o == (m_ph == 1 || m_ph == 2), "R9 busy", int'(busy_o), int'(m_ph == 1 || m_ph == 2));
            check(eoc_o == (m_ph == 3), "R6 eoc", int'(eoc_o), int'(m_ph == 3));
            check(result_o == W'(m_res) && over_range_o == m_ovr[0], "R4 R8 result",
                  int'(result_o), m_res);
        end
        if (sw_sel_o[0])      acc = acc + vin;
        else if (sw_sel_o[1]) acc = acc - vref;
        else                  acc = 0;
        zero_cross_i = (sw_sel_o[1] && acc <= 0) || (force_zc && sw_sel_o[0]);
    end

    function automatic int exp_code(input int vi, input int vr);
        int c;
        if (vi == 0) return 0;
        c = (N*vi + vr - 1) / vr - 1;
        return (c > N-1) ? N-1 : c;
    endfunction

    task automatic convert(input int vi, input int vr, input bit restart, input string tag);
        int len_in = 0, exp_r;
        bit exp_o;
        vin = vi; vref = vr;
        exp_r = exp_code(vi, vr);
        exp_o = ((N*vi + vr - 1) / vr - 1) > N-1;
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        while (!eoc_o) begin
            if (sw_sel_o[0]) len_in++;
            if (restart && len_in == 50) start_i = 1'b1;
            else if (restart && len_in == 51) start_i = 1'b0;
            @(negedge clk);
        end
        start_i = 1'b0;
        check(len_in == N, {tag, " R3 input phase length"}, len_in, N);
        check(result_o == W'(exp_r), {tag, " R4 R5 result"}, int'(result_o), exp_r);
        check(over_range_o == exp_o, {tag, " R5 over-range"}, int'(over_range_o), int'(exp_o));
        @(negedge clk);
        check(!eoc_o && sw_sel_o == 3'b100, {tag, " R6 back to idle"}, int'(eoc_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(sw_sel_o == 3'b100, "R1 reset select", int'(sw_sel_o), 4);
        check(!eoc_o && !busy_o, "R1 reset flags", int'({eoc_o, busy_o}), 0);
        check(result_o == 0 && !over_range_o, "R1 reset result", int'(result_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        convert(100, 256, 0, "mid");
        convert(0, 256, 0, "zero R4");
        convert(37, 100, 0, "ratio");
        convert(256, 256, 0, "fullscale R5");
        convert(300, 256, 0, "overrange R5");
        convert(10, 64, 0, "clear ovr R5");
        force_zc = 1;
        convert(80, 200, 0, "zc during input R4");
        force_zc = 0;
        convert(120, 256, 1, "start while busy R7");

        // R8: outputs hold in idle while comparator toggles
        begin
            logic [W-1:0] keep;
            keep = result_o;
            repeat (20) begin
                @(negedge clk);
                zero_cross_i = ~zero_cross_i;
            end
            @(negedge clk);
            check(result_o == keep && !over_range_o, "R8 idle hold", int'(result_o), int'(keep));
            check(sw_sel_o == 3'b100, "R4 zc ignored in idle", int'(sw_sel_o), 4);
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fail++;
            $display("FAIL watchdog R6 actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule